// File: doc/BRIEF.md
# Segmented Pixel Nonuniformity Statistics Engine

This block watches a stream of digitised pixel samples for one colour line and divides the line into a fixed run of segments. For every segment it reports the brightest and darkest sample, the integer mean, and a nonuniformity figure equal to half the brightest-to-darkest spread relative to the mean. The figure is given in tenths of a percent. When the final segment of a line has been reported, it also gives the worst figure on the line and the segment where that figure occurred.

Samples arrive with a valid qualifier. A start-of-line marker comes with the first sample of each line. With default parameters a line holds 7078 samples: 61 segments of 114 samples and then one closing segment of 124. When a segment closes, one shared sequential divider runs twice. The first pass finds the mean and the second finds the figure. The result record therefore appears a fixed number of cycles after the closing sample. If a start-of-line marker arrives before the line is complete, the line is abandoned and a short-line pulse is raised.

Top module: `pnu_stats_engine`

## Requirements
- R1: A line is cut into NUM_SEG segments, numbered 0 upward in arrival order. Every segment holds SEG_LEN accepted samples except the final one (index NUM_SEG-1), which holds LAST_LEN (defaults 62, 114, 124). `seg_idx_o` carries the index of the reported segment.
- R2: `seg_max_o` and `seg_min_o` are the largest and smallest unsigned sample of the segment.
- R3: `seg_mean_o` is the floor of the segment's sample sum divided by its length.
- R4: `seg_fig_o` is floor((max − min) × 500 / mean), which is the nonuniformity in units of 0.1 %. It is clamped to 65535 when larger.
- R5: When the mean is 0, `seg_fig_o` is 65535 and `seg_zero_err_o` is 1. Otherwise `seg_zero_err_o` is 0.
- R6: `seg_valid_o` is a one-cycle strobe. It is high exactly 2×(DATA_W+9)+4 cycles after the cycle that presented the segment's closing sample, which is 46 cycles with defaults.
- R7: `line_done_o` is high together with the record of segment NUM_SEG-1. In that cycle `worst_fig_o` and `worst_idx_o` give the largest figure of the line and its segment index. On a tie the lowest index wins.
- R8: A sample with `in_valid_i` and `in_sol_i` high while a line is still open aborts that line. The open partial segment is dropped and produces no record. The aborted line never raises `line_done_o`. `short_line_o` pulses in the following cycle, and the marker sample becomes sample 0 of segment 0 of a new line.
- R9: Samples presented while no line is open and without the marker are ignored. A marker without `in_valid_i` is ignored. Cycles with `in_valid_i` low are not counted.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Sample qualifier |
| in_sol_i | input | 1 | Start-of-line marker, qualified by in_valid_i |
| in_data_i | input | DATA_W | Unsigned pixel sample |
| seg_valid_o | output | 1 | Record strobe |
| seg_idx_o | output | IDX_W | Segment index of the record |
| seg_max_o | output | DATA_W | Largest sample of the segment |
| seg_min_o | output | DATA_W | Smallest sample of the segment |
| seg_mean_o | output | DATA_W | Floor mean of the segment |
| seg_fig_o | output | FIG_W | Nonuniformity, 0.1 % units, clamped |
| seg_zero_err_o | output | 1 | Mean was zero |
| line_done_o | output | 1 | Final segment of a full line reported |
| worst_fig_o | output | FIG_W | Worst figure of the line |
| worst_idx_o | output | IDX_W | Segment of the worst figure |
| short_line_o | output | 1 | Line aborted by an early marker |

## Verification
An address-like ramp produces a different spread and mean in every segment, so it separates wrong segment boundaries and wrong max, min or mean capture. A flat line with regular idle cycles must give figure 0 throughout and shows that gaps are not counted as samples. A crafted line places an all-zero segment (saturation with the error flag) and a segment holding a single small spike (saturation by clamp, no flag) at two different indices with equal worst figures, which exercises the tie rule. Stray samples before a line, an early marker that aborts a partly received line, and a pseudo-random line after the abort test the R8 and R9 behaviour and the cycle-exact record timing.

// File: rtl/pnu_pkg.sv
package pnu_pkg;
  // Scale turning (max-min)/(2*mean) into tenths of a percent.
  localparam int unsigned PCT_SCALE = 500;
  localparam int unsigned PCT_BITS  = 9;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_MEAN = 2'd1,
    RS_FIG  = 2'd2
  } rs_state_e;
endpackage

// File: rtl/pnu_seg_accum.sv
module pnu_seg_accum #(
  parameter int DATA_W   = 12,
  parameter int SEG_LEN  = 114,
  parameter int LAST_LEN = 124,
  parameter int NUM_SEG  = 62,
  parameter int CNT_W    = 7,
  parameter int IDX_W    = 6,
  parameter int SUM_W    = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic              in_sol_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              close_o,
  output logic              abort_o,
  output logic [DATA_W-1:0] snap_max_o,
  output logic [DATA_W-1:0] snap_min_o,
  output logic [SUM_W-1:0]  snap_sum_o,
  output logic [CNT_W-1:0]  snap_len_o,
  output logic [IDX_W-1:0]  snap_idx_o,
  output logic              snap_last_o
);
  localparam logic [CNT_W-1:0] END_STD  = CNT_W'(SEG_LEN - 1);
  localparam logic [CNT_W-1:0] END_FIN  = CNT_W'(LAST_LEN - 1);
  localparam logic [CNT_W-1:0] LEN_STD  = CNT_W'(SEG_LEN);
  localparam logic [CNT_W-1:0] LEN_FIN  = CNT_W'(LAST_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SEG - 1);

  function automatic logic [DATA_W-1:0] pick_hi(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [DATA_W-1:0] pick_lo(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic              active_q;
  logic [IDX_W-1:0]  seg_q;
  logic [CNT_W-1:0]  pos_q;
  logic [DATA_W-1:0] max_q, min_q;
  logic [SUM_W-1:0]  sum_q;

  logic              take, fresh, is_fin, closing;
  logic [IDX_W-1:0]  seg_eff;
  logic [CNT_W-1:0]  pos_eff;
  logic [DATA_W-1:0] nxt_max, nxt_min;
  logic [SUM_W-1:0]  nxt_sum;

  always_comb begin
    take    = in_valid_i && (in_sol_i || active_q);
    seg_eff = in_sol_i ? '0 : seg_q;
    pos_eff = in_sol_i ? '0 : pos_q;
    fresh   = (pos_eff == '0);
    is_fin  = (seg_eff == LAST_IDX);
    closing = take && (pos_eff == (is_fin ? END_FIN : END_STD));
    nxt_max = fresh ? in_data_i : pick_hi(max_q, in_data_i);
    nxt_min = fresh ? in_data_i : pick_lo(min_q, in_data_i);
    nxt_sum = fresh ? SUM_W'(in_data_i) : sum_q + SUM_W'(in_data_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      seg_q       <= '0;
      pos_q       <= '0;
      max_q       <= '0;
      min_q       <= '0;
      sum_q       <= '0;
      close_o     <= 1'b0;
      abort_o     <= 1'b0;
      snap_max_o  <= '0;
      snap_min_o  <= '0;
      snap_sum_o  <= '0;
      snap_len_o  <= '0;
      snap_idx_o  <= '0;
      snap_last_o <= 1'b0;
    end else begin
      close_o <= closing;
      abort_o <= in_valid_i && in_sol_i && active_q;
      if (take) begin
        max_q <= nxt_max;
        min_q <= nxt_min;
        sum_q <= nxt_sum;
        if (closing) begin
          snap_max_o  <= nxt_max;
          snap_min_o  <= nxt_min;
          snap_sum_o  <= nxt_sum;
          snap_len_o  <= is_fin ? LEN_FIN : LEN_STD;
          snap_idx_o  <= seg_eff;
          snap_last_o <= is_fin;
          pos_q       <= '0;
          seg_q       <= is_fin ? '0 : seg_eff + 1'b1;
          active_q    <= !is_fin;
        end else begin
          pos_q    <= pos_eff + 1'b1;
          seg_q    <= seg_eff;
          active_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pnu_seq_div.sv
module pnu_seq_div #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  // One restoring step: returns {remainder, quotient}.
  function automatic logic [2*W-1:0] div_step(input logic [W-1:0] rem,
                                               input logic [W-1:0] quo,
                                               input logic [W-1:0] dv);
    logic [W:0] shifted, diff;
    logic       neg;
    shifted = {rem, quo[W-1]};
    diff    = shifted - {1'b0, dv};
    neg     = diff[W];
    return {(neg ? shifted[W-1:0] : diff[W-1:0]), quo[W-2:0], ~neg};
  endfunction

  logic [W-1:0]  rem_q, dv_q;
  logic [CW-1:0] step_q;
  logic [2*W-1:0] nxt;

  assign nxt = div_step(rem_q, quot_o, dv_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dv_q   <= '0;
      quot_o <= '0;
      step_q <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        dv_q   <= divisor_i;
        quot_o <= dividend_i;
        step_q <= '0;
        busy_o <= 1'b1;
      end else if (busy_o) begin
        rem_q  <= nxt[2*W-1:W];
        quot_o <= nxt[W-1:0];
        if (step_q == LAST_STEP) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pnu_result_seq.sv
module pnu_result_seq
  import pnu_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 7,
  parameter int IDX_W  = 6,
  parameter int SUM_W  = 19,
  parameter int DIV_W  = 21,
  parameter int FIG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close_i,
  input  logic [DATA_W-1:0] snap_max_i,
  input  logic [DATA_W-1:0] snap_min_i,
  input  logic [SUM_W-1:0]  snap_sum_i,
  input  logic [CNT_W-1:0]  snap_len_i,
  input  logic [IDX_W-1:0]  snap_idx_i,
  input  logic              snap_last_i,
  input  logic              div_done_i,
  input  logic [DIV_W-1:0]  div_quot_i,
  output logic              div_start_o,
  output logic [DIV_W-1:0]  div_dividend_o,
  output logic [DIV_W-1:0]  div_divisor_o,
  output logic              seg_valid_o,
  output logic [IDX_W-1:0]  seg_idx_o,
  output logic [DATA_W-1:0] seg_max_o,
  output logic [DATA_W-1:0] seg_min_o,
  output logic [DATA_W-1:0] seg_mean_o,
  output logic [FIG_W-1:0]  seg_fig_o,
  output logic              seg_zero_err_o,
  output logic              line_done_o,
  output logic [FIG_W-1:0]  worst_fig_o,
  output logic [IDX_W-1:0]  worst_idx_o
);
  function automatic logic [DIV_W-1:0] scaled_range(input logic [DATA_W-1:0] hi, input logic [DATA_W-1:0] lo);
    return DIV_W'(hi - lo) * DIV_W'(PCT_SCALE);
  endfunction

  function automatic logic [FIG_W-1:0] clamp_fig(input logic [DIV_W-1:0] q);
    return (|q[DIV_W-1:FIG_W]) ? '1 : q[FIG_W-1:0];
  endfunction

  rs_state_e         state_q;
  logic [DATA_W-1:0] h_max, h_min, mean_q;
  logic [IDX_W-1:0]  h_idx;
  logic              h_last;
  logic [FIG_W-1:0]  run_fig;
  logic [IDX_W-1:0]  run_idx;

  logic              mean_ready, fig_ready, zero_mean, better;
  logic [DATA_W-1:0] mean_w;
  logic [FIG_W-1:0]  fig_w;

  always_comb begin
    mean_w         = div_quot_i[DATA_W-1:0];
    mean_ready     = (state_q == RS_MEAN) && div_done_i;
    fig_ready      = (state_q == RS_FIG) && div_done_i;
    div_start_o    = close_i || mean_ready;
    div_dividend_o = close_i ? DIV_W'(snap_sum_i) : scaled_range(h_max, h_min);
    div_divisor_o  = close_i ? DIV_W'(snap_len_i)
                             : ((mean_w == '0) ? DIV_W'(1) : DIV_W'(mean_w));
    zero_mean      = (mean_q == '0);
    fig_w          = zero_mean ? '1 : clamp_fig(div_quot_i);
    better         = (h_idx == '0) || (fig_w > run_fig);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= RS_IDLE;
      h_max          <= '0;
      h_min          <= '0;
      h_idx          <= '0;
      h_last         <= 1'b0;
      mean_q         <= '0;
      run_fig        <= '0;
      run_idx        <= '0;
      seg_valid_o    <= 1'b0;
      seg_idx_o      <= '0;
      seg_max_o      <= '0;
      seg_min_o      <= '0;
      seg_mean_o     <= '0;
      seg_fig_o      <= '0;
      seg_zero_err_o <= 1'b0;
      line_done_o    <= 1'b0;
      worst_fig_o    <= '0;
      worst_idx_o    <= '0;
    end else begin
      seg_valid_o <= 1'b0;
      line_done_o <= 1'b0;
      if (close_i) begin
        h_max   <= snap_max_i;
        h_min   <= snap_min_i;
        h_idx   <= snap_idx_i;
        h_last  <= snap_last_i;
        state_q <= RS_MEAN;
      end else if (mean_ready) begin
        mean_q  <= mean_w;
        state_q <= RS_FIG;
      end else if (fig_ready) begin
        state_q        <= RS_IDLE;
        seg_valid_o    <= 1'b1;
        seg_idx_o      <= h_idx;
        seg_max_o      <= h_max;
        seg_min_o      <= h_min;
        seg_mean_o     <= mean_q;
        seg_fig_o      <= fig_w;
        seg_zero_err_o <= zero_mean;
        if (better) begin
          run_fig <= fig_w;
          run_idx <= h_idx;
        end
        if (h_last) begin
          line_done_o <= 1'b1;
          worst_fig_o <= better ? fig_w : run_fig;
          worst_idx_o <= better ? h_idx : run_idx;
        end
      end
    end
  end
endmodule

// File: rtl/pnu_stats_engine.sv
module pnu_stats_engine
  import pnu_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int SEG_LEN  = 114,
  parameter int LAST_LEN = 124,
  parameter int NUM_SEG  = 62,
  parameter int FIG_W    = 16,
  localparam int CNT_W   = $clog2(LAST_LEN + 1),
  localparam int IDX_W   = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic              in_sol_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              seg_valid_o,
  output logic [IDX_W-1:0]  seg_idx_o,
  output logic [DATA_W-1:0] seg_max_o,
  output logic [DATA_W-1:0] seg_min_o,
  output logic [DATA_W-1:0] seg_mean_o,
  output logic [FIG_W-1:0]  seg_fig_o,
  output logic              seg_zero_err_o,
  output logic              line_done_o,
  output logic [FIG_W-1:0]  worst_fig_o,
  output logic [IDX_W-1:0]  worst_idx_o,
  output logic              short_line_o
);
  localparam int SUM_W  = DATA_W + CNT_W;
  localparam int PROD_W = DATA_W + int'(PCT_BITS);
  localparam int DIV_W  = (SUM_W > PROD_W) ? SUM_W : PROD_W;

  // Named internal events, observed by the bound checker.
  logic              seg_close;
  logic              seg_abort;
  logic              div_start;
  logic              div_busy;
  logic              div_done;
  logic [DIV_W-1:0]  div_quot, div_dividend, div_divisor;
  logic [DATA_W-1:0] snap_max, snap_min;
  logic [SUM_W-1:0]  snap_sum;
  logic [CNT_W-1:0]  snap_len;
  logic [IDX_W-1:0]  snap_idx;
  logic              snap_last;

  pnu_seg_accum #(
    .DATA_W(DATA_W), .SEG_LEN(SEG_LEN), .LAST_LEN(LAST_LEN), .NUM_SEG(NUM_SEG),
    .CNT_W(CNT_W), .IDX_W(IDX_W), .SUM_W(SUM_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_n),
    .in_valid_i(in_valid_i), .in_sol_i(in_sol_i), .in_data_i(in_data_i),
    .close_o(seg_close), .abort_o(seg_abort),
    .snap_max_o(snap_max), .snap_min_o(snap_min), .snap_sum_o(snap_sum),
    .snap_len_o(snap_len), .snap_idx_o(snap_idx), .snap_last_o(snap_last)
  );

  pnu_seq_div #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n),
    .start_i(div_start), .dividend_i(div_dividend), .divisor_i(div_divisor),
    .busy_o(div_busy), .done_o(div_done), .quot_o(div_quot)
  );

  pnu_result_seq #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .SUM_W(SUM_W),
    .DIV_W(DIV_W), .FIG_W(FIG_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .close_i(seg_close),
    .snap_max_i(snap_max), .snap_min_i(snap_min), .snap_sum_i(snap_sum),
    .snap_len_i(snap_len), .snap_idx_i(snap_idx), .snap_last_i(snap_last),
    .div_done_i(div_done), .div_quot_i(div_quot),
    .div_start_o(div_start), .div_dividend_o(div_dividend), .div_divisor_o(div_divisor),
    .seg_valid_o(seg_valid_o), .seg_idx_o(seg_idx_o),
    .seg_max_o(seg_max_o), .seg_min_o(seg_min_o), .seg_mean_o(seg_mean_o),
    .seg_fig_o(seg_fig_o), .seg_zero_err_o(seg_zero_err_o),
    .line_done_o(line_done_o), .worst_fig_o(worst_fig_o), .worst_idx_o(worst_idx_o)
  );

  assign short_line_o = seg_abort;
endmodule

// File: rtl/pnu_stats_checker.sv
module pnu_stats_checker #(
  parameter int DATA_W  = 12,
  parameter int IDX_W   = 6,
  parameter int FIG_W   = 16,
  parameter int NUM_SEG = 62
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid_i,
  input logic              in_sol_i,
  input logic              div_start,
  input logic              div_busy,
  input logic              seg_valid_o,
  input logic [IDX_W-1:0]  seg_idx_o,
  input logic [DATA_W-1:0] seg_max_o,
  input logic [DATA_W-1:0] seg_min_o,
  input logic [DATA_W-1:0] seg_mean_o,
  input logic [FIG_W-1:0]  seg_fig_o,
  input logic              seg_zero_err_o,
  input logic              line_done_o,
  input logic [FIG_W-1:0]  worst_fig_o,
  input logic              short_line_o
);
  p_start_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |-> !div_busy);

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid_o |=> !seg_valid_o);

  p_max_ge_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid_o |-> seg_max_o >= seg_min_o);

  p_mean_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid_o |-> (seg_mean_o >= seg_min_o) && (seg_mean_o <= seg_max_o));

  p_zero_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid_o && seg_zero_err_o) |-> (seg_fig_o == {FIG_W{1'b1}}));

  p_done_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_done_o |-> (seg_valid_o && seg_idx_o == IDX_W'(NUM_SEG - 1)));

  p_worst_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_done_o |-> worst_fig_o >= seg_fig_o);

  p_abort_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    short_line_o |-> $past(in_valid_i && in_sol_i));
endmodule

bind pnu_stats_engine pnu_stats_checker #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .FIG_W(FIG_W), .NUM_SEG(NUM_SEG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_sol_i(in_sol_i),
  .div_start(div_start), .div_busy(div_busy),
  .seg_valid_o(seg_valid_o), .seg_idx_o(seg_idx_o),
  .seg_max_o(seg_max_o), .seg_min_o(seg_min_o), .seg_mean_o(seg_mean_o),
  .seg_fig_o(seg_fig_o), .seg_zero_err_o(seg_zero_err_o),
  .line_done_o(line_done_o), .worst_fig_o(worst_fig_o), .short_line_o(short_line_o)
);

// File: tb/pnu_stats_engine_tb.sv
module pnu_stats_engine_tb_top;
  localparam int LAT = 46;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sol = 1'b0;
  logic [11:0] in_data = '0;
  logic        seg_valid, seg_zero_err, line_done, short_line;
  logic [5:0]  seg_idx, worst_idx;
  logic [11:0] seg_max, seg_min, seg_mean;
  logic [15:0] seg_fig, worst_fig;

  pnu_stats_engine dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_sol_i(in_sol), .in_data_i(in_data),
    .seg_valid_o(seg_valid), .seg_idx_o(seg_idx), .seg_max_o(seg_max), .seg_min_o(seg_min),
    .seg_mean_o(seg_mean), .seg_fig_o(seg_fig), .seg_zero_err_o(seg_zero_err),
    .line_done_o(line_done), .worst_fig_o(worst_fig), .worst_idx_o(worst_idx),
    .short_line_o(short_line)
  );

  always #5 clk = ~clk;

  typedef struct {
    int due; int idx; int mx; int mn; int mean; int fig; int err;
    int done; int wfig; int widx;
  } rec_t;

  rec_t exp_q[$];
  int   short_q[$];
  int   cyc = 0;
  int   errors = 0;
  int   checks = 0;
  bit   started = 0;
  bit   finished = 0;

  // Reference model state
  int m_act = 0, m_seg = 0, m_pos = 0, m_mx = 0, m_mn = 0, m_sum = 0, m_wf = 0, m_wi = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, expv);
    end
  endtask

  task automatic model_step(input bit v, input bit s, input int d);
    int len, mean, fig, err;
    rec_t r;
    if (!v) return;
    if (s && m_act != 0) short_q.push_back(cyc + 1);
    if (s) begin m_act = 1; m_seg = 0; m_pos = 0; end
    else if (m_act == 0) return;
    if (m_pos == 0) begin m_mx = d; m_mn = d; m_sum = d; end
    else begin
      if (d > m_mx) m_mx = d;
      if (d < m_mn) m_mn = d;
      m_sum += d;
    end
    len = (m_seg == 61) ? 124 : 114;
    m_pos++;
    if (m_pos == len) begin
      mean = m_sum / len;
      if (mean == 0) begin fig = 65535; err = 1; end
      else begin
        fig = (m_mx - m_mn) * 500 / mean;
        if (fig > 65535) fig = 65535;
        err = 0;
      end
      if (m_seg == 0 || fig > m_wf) begin m_wf = fig; m_wi = m_seg; end
      r.due = cyc + LAT; r.idx = m_seg; r.mx = m_mx; r.mn = m_mn; r.mean = mean;
      r.fig = fig; r.err = err; r.done = (m_seg == 61) ? 1 : 0; r.wfig = m_wf; r.widx = m_wi;
      exp_q.push_back(r);
      m_pos = 0;
      if (m_seg == 61) m_act = 0; else m_seg++;
    end
  endtask

  task automatic drive(input bit v, input bit s, input int d);
    @(posedge clk);
    #1;
    in_valid = v; in_sol = s; in_data = 12'(d);
    model_step(v, s, d);
  endtask

  // Monitor: compare against the model every cycle, away from the edge.
  always @(negedge clk) begin
    if (rst_n && started && !finished) begin
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        rec_t e;
        e = exp_q.pop_front();
        chk(seg_valid == 1'b1, "R6 record strobe timing", int'(seg_valid), 1);
        chk(int'(seg_idx) == e.idx, "R1 segment index", int'(seg_idx), e.idx);
        chk(int'(seg_max) == e.mx, "R2 segment max", int'(seg_max), e.mx);
        chk(int'(seg_min) == e.mn, "R2 segment min", int'(seg_min), e.mn);
        chk(int'(seg_mean) == e.mean, "R3 segment mean", int'(seg_mean), e.mean);
        chk(int'(seg_fig) == e.fig, "R4 figure", int'(seg_fig), e.fig);
        chk(int'(seg_zero_err) == e.err, "R5 zero-mean flag", int'(seg_zero_err), e.err);
        chk(int'(line_done) == e.done, "R7 line done", int'(line_done), e.done);
        if (e.done != 0) begin
          chk(int'(worst_fig) == e.wfig, "R7 worst figure", int'(worst_fig), e.wfig);
          chk(int'(worst_idx) == e.widx, "R7 worst index", int'(worst_idx), e.widx);
        end
      end else if (seg_valid || line_done) begin
        chk(1'b0, "R6 unexpected record", int'(seg_valid), 0);
      end
      if (short_q.size() > 0 && short_q[0] == cyc) begin
        void'(short_q.pop_front());
        chk(short_line == 1'b1, "R8 short-line pulse", int'(short_line), 1);
      end else if (short_line) begin
        chk(1'b0, "R8 unexpected short-line", 1, 0);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 200000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 200000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lf;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk({seg_valid, seg_zero_err, line_done, short_line} == 4'b0, "R10 reset flags", 0, 0);
    chk(seg_idx == 0 && seg_max == 0 && seg_min == 0 && seg_mean == 0, "R10 reset record", int'(seg_max), 0);
    chk(seg_fig == 0 && worst_fig == 0 && worst_idx == 0, "R10 reset worst", int'(worst_fig), 0);
    rst_n = 1'b1;
    started = 1;

    // R9: stray samples with no open line, then a marker without valid
    for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, 4000);
    drive(1'b0, 1'b1, 0);
    drive(1'b0, 1'b0, 0);

    // R1-R6: ramp line, back to back
    for (int i = 0; i < 7078; i++) drive(1'b1, i == 0, (i * 37) % 4096);

    // R4/R9: flat line with idle gaps
    for (int i = 0; i < 7078; i++) begin
      drive(1'b1, i == 0, 1000);
      if (i % 3 == 2) drive(1'b0, 1'b0, 55);
    end

    // R5/R7: zero segment 5, spike segment 10 -> equal saturated figures, tie
    for (int i = 0; i < 7078; i++) begin
      int d;
      if (i >= 570 && i < 684) d = 0;
      else if (i == 1140) d = 227;
      else if (i > 1140 && i < 1254) d = 0;
      else d = 2000 + (i % 7) * 10;
      drive(1'b1, i == 0, d);
    end

    // R8: early marker aborts a partial line after 300 samples
    for (int i = 0; i < 300; i++) drive(1'b1, i == 0, 100 + i);
    lf = 32'h1234_5678;
    for (int i = 0; i < 7078; i++) begin
      lf = lf * 1103515245 + 12345;
      drive(1'b1, i == 0, (lf >>> 16) & 12'hfff);
    end
    drive(1'b0, 1'b0, 0);

    repeat (LAT + 20) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R6 all records delivered", exp_q.size(), 0);
    chk(short_q.size() == 0, "R8 all short pulses delivered", short_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule